// File: doc/BRIEF.md
# Outbound Message Descriptor Engine

This block sends messages described by entries in a circular descriptor ring that lives in local memory. Software writes a descriptor into the ring slot at the enqueue index and then bumps the enqueue index through a control write. When the engine is enabled and the ring is not empty, it reads the descriptor at the dequeue index. It then reads every payload segment of that message into a small local buffer and hands the segments, one at a time, to a transmit port that reports one outcome per segment.

A descriptor either names one destination or, when broadcast-to-mask mode is on, carries a bit mask of destinations. Each selected destination receives the whole message, and destinations are served in ascending index order. Per-segment outcomes feed sticky, write-one-to-clear status flags. Some of these flags stop the engine: at once, or once the current message has finished. An error interrupt can be enabled for them. After a stop, clearing the flags lets the engine go on with the descriptors that are still waiting.

Descriptor word: bits [AW-1:0] hold the payload word address, the next SEG_W bits hold the segment count minus one, the next NT bits hold the destination mask, and the next log2(NT) bits hold the single destination index. Memory addresses are word addresses. Descriptor slot k is at DESC_BASE + k.

Top module: `msg_out_engine`

## Requirements
- R1: After reset the ring is empty (both indices 0), the status word reads 0x04, irq is low, and neither mem_req nor tx_valid is asserted.
- R2: A descriptor is read only while the enable bit (control bit 0) is set, the ring is not empty and no stopping flag (error response, retry overrun, memory error) is set. It is read from DESC_BASE plus the dequeue index. No new descriptor is read until the current one has been retired.
- R3: Status bit 2 (empty) is set when the indices are equal. Status bit 1 (full) is set when enqueue+1 equals dequeue. Writing control bit 3 advances the enqueue index by one, except when the ring is full, in which case the write leaves the index unchanged.
- R4: After the descriptor read, segments 0..n-1 are read in order from payload address + k, all of them before the first segment is transmitted.
- R5: In single-destination mode (control bit 1 clear), each segment is sent in order to the descriptor's destination index, with tx_last set on the final segment. The dequeue index then advances by one.
- R6: In mask mode (control bit 1 set), every destination whose mask bit is set receives all segments, in ascending destination order. A zero mask sends nothing and still retires the descriptor.
- R7: Outcome code 2 (response time-out) sets status bit 4. Processing continues as after a normal completion.
- R8: Outcome code 1 (error response) sets status bit 3. The rest of the current message is still sent to all its destinations and the descriptor is retired. After that, no further descriptor is read.
- R9: Outcome code 3 (retry overrun) sets status bit 5 and stops the engine at once. No further segment is sent, and the dequeue index stays on that descriptor, so the whole message is sent again on resume.
- R10: A memory error on a descriptor or payload read sets status bit 6. It drops the descriptor without sending it, advances the dequeue index, and stops the engine.
- R11: irq is high exactly while control bit 2 is set and at least one of status bits 3..6 is set.
- R12: Writing 1 to status bits 3..6 clears them. Once no stopping flag remains, pending descriptors are processed again.
- R13: Status bit 0 (busy) is set while a descriptor is in progress and reads 0 when the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 enqueue index, 2 dequeue index (read-only), 3 status |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | AW | Memory read word address |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | DW | Memory read data |
| mem_rerr | input | 1 | Memory read error, qualified by mem_rvalid |
| tx_valid | output | 1 | Segment offered for transmission, held until outcome |
| tx_target | output | log2(NT) | Destination index of the segment |
| tx_data | output | DW | Segment payload |
| tx_last | output | 1 | Final segment of the message for this destination |
| tx_done | input | 1 | Outcome valid for the offered segment |
| tx_outcome | input | 2 | 0 done, 1 error response, 2 time-out, 3 retry overrun |
| irq | output | 1 | Error interrupt |

## Verification
The bench fills the ring up to full and tries one extra increment, which a wrong full test would turn into an apparently empty ring that loses seven messages. It injects each non-normal outcome partway through a message. A design that treated an error response like a retry overrun would cut the message short, and one that treated a retry overrun like an error response would retire the descriptor instead of sending it again. A memory error is placed on a middle payload word to catch a design that sends partial data or keeps fetching. Mask mode with sparse and zero masks, and enqueueing that wraps past the ring end, expose a wrong destination order or wrong index wrap.

// File: rtl/msg_out_engine.sv
module msg_out_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int PTR_W = 3,
  parameter int SEG_W = 4,
  parameter int NT = 4,
  parameter logic [15:0] DESC_BASE = 16'h0100,
  localparam int TI_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rerr,
  output logic            tx_valid,
  output logic [TI_W-1:0] tx_target,
  output logic [DW-1:0]   tx_data,
  output logic            tx_last,
  input  logic            tx_done,
  input  logic [1:0]      tx_outcome,
  output logic            irq
);
  localparam int NSEG = 1 << SEG_W;
  localparam int SC_LSB = AW;
  localparam int MK_LSB = AW + SEG_W;
  localparam int DS_LSB = AW + SEG_W + NT;

  typedef enum logic [1:0] {S_IDLE, S_DESC, S_LOAD, S_SEND} st_t;
  st_t st;

  logic [PTR_W-1:0] enq, deq;
  logic en, mc, eie, mer, prt, rete, te;
  logic [AW-1:0] pay;
  logic [SEG_W-1:0] seg_i, last_i;
  logic [NT-1:0] pend;
  logic [DW-1:0] sbuf [NSEG];
  logic [TI_W-1:0] cur;

  wire q_empty = enq == deq;
  wire q_full  = PTR_W'(enq + 1'b1) == deq;
  wire halt    = mer | rete | te;
  wire ctrl_wr = reg_wr && reg_addr == 2'd0;
  wire enq_wr  = reg_wr && reg_addr == 2'd1;
  wire stat_wr = reg_wr && reg_addr == 2'd3;
  wire mem_ack = mem_req && mem_rvalid;
  wire tx_ack  = tx_valid && tx_done;
  wire [NT-1:0] cur_oh = pend & (~pend + 1'b1);
  wire [NT-1:0] rem    = pend & ~cur_oh;
  wire [NT-1:0] d_mask = mc ? mem_rdata[MK_LSB +: NT]
                            : NT'(1) << mem_rdata[DS_LSB +: TI_W];

  always_comb begin
    cur = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (pend[i]) cur = TI_W'(i);
  end

  assign mem_req   = st == S_DESC || st == S_LOAD;
  assign mem_addr  = (st == S_DESC) ? AW'(DESC_BASE) + AW'(deq) : pay + AW'(seg_i);
  assign tx_valid  = st == S_SEND;
  assign tx_target = cur;
  assign tx_data   = sbuf[seg_i];
  assign tx_last   = seg_i == last_i;
  assign irq       = eie & (mer | prt | rete | te);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[2:0] = {eie, mc, en};
      2'd1: reg_rdata[PTR_W-1:0] = enq;
      2'd2: reg_rdata[PTR_W-1:0] = deq;
      default: reg_rdata[6:0] = {te, rete, prt, mer, q_empty, q_full, st != S_IDLE};
    endcase
  end

  always_ff @(posedge clk)
    if (st == S_LOAD && mem_ack && !mem_rerr) sbuf[seg_i] <= mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      enq <= '0; deq <= '0;
      en <= 1'b0; mc <= 1'b0; eie <= 1'b0;
      mer <= 1'b0; prt <= 1'b0; rete <= 1'b0; te <= 1'b0;
      pay <= '0; seg_i <= '0; last_i <= '0; pend <= '0;
    end else begin
      if (ctrl_wr) begin
        en  <= reg_wdata[0];
        mc  <= reg_wdata[1];
        eie <= reg_wdata[2];
        if (reg_wdata[3] && !q_full) enq <= enq + 1'b1;
      end
      if (enq_wr) enq <= reg_wdata[PTR_W-1:0];
      if (stat_wr) begin
        if (reg_wdata[3]) mer  <= 1'b0;
        if (reg_wdata[4]) prt  <= 1'b0;
        if (reg_wdata[5]) rete <= 1'b0;
        if (reg_wdata[6]) te   <= 1'b0;
      end
      case (st)
        S_IDLE:
          if (en && !q_empty && !halt) st <= S_DESC;
        S_DESC:
          if (mem_ack) begin
            if (mem_rerr) begin
              te <= 1'b1;
              deq <= deq + 1'b1;
              st <= S_IDLE;
            end else begin
              pay    <= mem_rdata[AW-1:0];
              last_i <= mem_rdata[SC_LSB +: SEG_W];
              pend   <= d_mask;
              seg_i  <= '0;
              st     <= S_LOAD;
            end
          end
        S_LOAD:
          if (mem_ack) begin
            if (mem_rerr) begin
              te <= 1'b1;
              deq <= deq + 1'b1;
              st <= S_IDLE;
            end else if (seg_i == last_i) begin
              seg_i <= '0;
              if (pend == '0) begin
                deq <= deq + 1'b1;
                st <= S_IDLE;
              end else st <= S_SEND;
            end else seg_i <= seg_i + 1'b1;
          end
        S_SEND:
          if (tx_ack) begin
            if (tx_outcome == 2'd3) begin
              rete <= 1'b1;
              seg_i <= '0;
              st <= S_IDLE;
            end else begin
              if (tx_outcome == 2'd1) mer <= 1'b1;
              if (tx_outcome == 2'd2) prt <= 1'b1;
              if (tx_last) begin
                seg_i <= '0;
                pend <= rem;
                if (rem == '0) begin
                  deq <= deq + 1'b1;
                  st <= S_IDLE;
                end
              end else seg_i <= seg_i + 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[3] && q_full && !enq_wr |=> $stable(enq));

  a_r2_desc_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_addr == AW'(DESC_BASE) + AW'(deq));

  a_r2_no_fetch_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && halt |=> !mem_req);

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_done |=> tx_valid && $stable(tx_target) && $stable(tx_data) && $stable(tx_last));

  a_r9_retry_stop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack && tx_outcome == 2'd3 |=> !tx_valid && !mem_req && $stable(deq));

  a_r11_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack && tx_outcome != 2'd0 && eie && !ctrl_wr |=> irq);
endmodule

// File: tb/msg_out_engine_tb_top.sv
`timescale 1ns/1ps
module msg_out_engine_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_rvalid = 0, mem_rerr = 0;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = 0;
  logic tx_valid, tx_last, tx_done = 0, irq;
  logic [1:0] tx_target, tx_outcome = 0;
  logic [31:0] tx_data;

  always #2.5 clk = ~clk;

  msg_out_engine dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] desc_mem [8];
  logic [15:0] mem_log [256];  int mem_n = 0;
  logic [34:0] tx_log [256];   int tx_n = 0;
  logic [15:0] emem [256];     int emem_n = 0;
  logic [34:0] etx [256];      int etx_n = 0;
  int inj_idx = -1;
  logic [1:0] inj_out = 0;
  bit err_en = 0;
  logic [15:0] err_addr = 0;
  logic [2:0] enq_m = 0;
  logic [31:0] ctl = 0;
  logic [31:0] rd;

  function automatic logic [31:0] mem_word(logic [15:0] a);
    if (a >= 16'h0100 && a < 16'h0108) return desc_mem[a[2:0]];
    return {a ^ 16'h5A5A, a};
  endfunction

  function automatic logic [31:0] mk_desc(logic [15:0] p, logic [3:0] nm1, logic [3:0] mk, logic [1:0] ds);
    return {6'b0, ds, mk, nm1, p};
  endfunction

  initial begin
    int dly = 0;
    forever begin
      @(posedge clk); #1;
      if (mem_rvalid) mem_rvalid = 0;
      else if (mem_req) begin
        if (dly == 0) begin
          mem_rdata = mem_word(mem_addr);
          mem_rerr = err_en && mem_addr == err_addr;
          mem_rvalid = 1;
          mem_log[mem_n] = mem_addr; mem_n++;
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  initial begin
    int dly = 0;
    forever begin
      @(posedge clk); #1;
      if (tx_done) tx_done = 0;
      else if (tx_valid) begin
        if (dly == 0) begin
          tx_outcome = (tx_n == inj_idx) ? inj_out : 2'd0;
          tx_done = 1;
          tx_log[tx_n] = {tx_target, tx_last, tx_data}; tx_n++;
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    int z = 0;
    logic [31:0] s;
    while (z < 2) begin
      reg_read(2'd3, s);
      if (s[0]) z = 0; else z++;
    end
  endtask

  task automatic clear_logs();
    mem_n = 0; tx_n = 0; emem_n = 0; etx_n = 0;
  endtask

  task automatic add_expect(logic [2:0] idx, bit m);
    logic [31:0] w = desc_mem[idx];
    logic [3:0] mask = m ? w[23:20] : 4'(1) << w[25:24];
    emem[emem_n] = 16'h0100 + 16'(idx); emem_n++;
    for (int s = 0; s <= int'(w[19:16]); s++) begin
      emem[emem_n] = w[15:0] + 16'(s); emem_n++;
    end
    for (int t = 0; t < 4; t++)
      if (mask[t])
        for (int s = 0; s <= int'(w[19:16]); s++) begin
          etx[etx_n] = {2'(t), s == int'(w[19:16]), mem_word(w[15:0] + 16'(s))};
          etx_n++;
        end
  endtask

  task automatic compare(string req);
    chk(mem_n == emem_n, {req, " read count"}, 64'(mem_n), 64'(emem_n));
    for (int i = 0; i < mem_n && i < emem_n; i++)
      chk(mem_log[i] == emem[i], {req, " read address order"}, 64'(mem_log[i]), 64'(emem[i]));
    chk(tx_n == etx_n, {req, " segment count"}, 64'(tx_n), 64'(etx_n));
    for (int i = 0; i < tx_n && i < etx_n; i++)
      chk(tx_log[i] == etx[i], {req, " segment target/last/data"}, 64'(tx_log[i]), 64'(etx[i]));
  endtask

  function automatic logic [2:0] enqueue_slot(logic [31:0] w);
    desc_mem[enq_m] = w;
    return enq_m;
  endfunction

  task automatic push(logic [31:0] w, output logic [2:0] idx);
    idx = enqueue_slot(w);
    reg_write(2'd0, ctl | 32'h8);
    enq_m = enq_m + 1'b1;
  endtask

  function automatic logic [31:0] rnd_desc();
    return mk_desc(16'h1000 + 16'($urandom % 16'h4000), 4'($urandom % 4), 4'($urandom), 2'($urandom));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] ix, i0, i1;
    void'($urandom(32'd777));
    for (int i = 0; i < 8; i++) desc_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    reg_read(2'd3, rd);
    chk(rd == 32'h4, "R1 status after reset", 64'(rd), 64'h4);
    chk(!irq && !mem_req && !tx_valid, "R1 outputs idle", 64'({irq, mem_req, tx_valid}), 0);
    reg_read(2'd1, rd);
    chk(rd == 0, "R1 enqueue index", 64'(rd), 0);

    // R3 fill to full while disabled, R2 no fetch when disabled
    clear_logs();
    for (int i = 0; i < 7; i++) begin
      push(rnd_desc(), ix);
      add_expect(ix, 0);
    end
    reg_read(2'd3, rd);
    chk(rd == 32'h2, "R3 full flag", 64'(rd), 64'h2);
    reg_write(2'd0, 32'h8);
    reg_read(2'd1, rd);
    chk(rd == 7, "R3 increment ignored when full", 64'(rd), 7);
    repeat (10) @(posedge clk);
    chk(mem_n == 0, "R2 no read while disabled", 64'(mem_n), 0);

    // R5 R4 R13 unicast run through wrap
    ctl = 32'h1;
    reg_write(2'd0, ctl);
    reg_read(2'd3, rd);
    chk(rd[0] == 1'b1, "R13 busy while processing", 64'(rd[0]), 1);
    wait_idle();
    compare("R5 R4 unicast");
    reg_read(2'd2, rd);
    chk(rd == 7, "R5 dequeue advanced", 64'(rd), 7);
    reg_read(2'd3, rd);
    chk(rd == 32'h4, "R13 idle and empty", 64'(rd), 64'h4);

    // R6 mask mode, wrapping indices, zero masks allowed
    clear_logs();
    ctl = 32'h3;
    reg_write(2'd0, 32'h2);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] w = rnd_desc();
      if (i == 2) w[23:20] = 4'b0000;
      if (i == 3) w[23:20] = 4'b1001;
      push(w, ix);
      add_expect(ix, 1);
    end
    reg_write(2'd0, ctl);
    wait_idle();
    compare("R6 multicast");

    // R7 time-out continues, R11 irq
    clear_logs();
    ctl = 32'h5;
    reg_write(2'd0, ctl);
    inj_idx = 1; inj_out = 2'd2;
    push(mk_desc(16'h2000, 4'd1, 4'd0, 2'd1), ix); add_expect(ix, 0);
    push(mk_desc(16'h2100, 4'd1, 4'd0, 2'd3), ix); add_expect(ix, 0);
    wait_idle();
    compare("R7 time-out continues");
    reg_read(2'd3, rd);
    chk(rd == 32'h14, "R7 time-out flag", 64'(rd), 64'h14);
    chk(irq == 1'b1, "R11 irq on time-out", 64'(irq), 1);
    inj_idx = -1;
    reg_write(2'd3, 32'h10);
    reg_read(2'd3, rd);
    chk(rd == 32'h4, "R12 clear time-out", 64'(rd), 64'h4);
    chk(irq == 1'b0, "R11 irq drops", 64'(irq), 0);

    // R8 error response finishes message then stops
    clear_logs();
    ctl = 32'h3;
    reg_write(2'd0, 32'h2);
    inj_idx = 1; inj_out = 2'd1;
    push(mk_desc(16'h3000, 4'd1, 4'b1010, 2'd0), i0);
    push(mk_desc(16'h3100, 4'd0, 4'b0001, 2'd0), i1);
    add_expect(i0, 1);
    reg_write(2'd0, ctl);
    wait_idle();
    compare("R8 message completes then stops");
    reg_read(2'd3, rd);
    chk(rd == 32'h8, "R8 error-response flag", 64'(rd), 64'h8);
    chk(irq == 1'b0, "R11 no irq when disabled", 64'(irq), 0);
    reg_read(2'd2, rd);
    chk(rd == 32'(i1), "R8 descriptor retired", 64'(rd), 64'(i1));
    clear_logs();
    inj_idx = -1;
    add_expect(i1, 1);
    reg_write(2'd3, 32'h8);
    wait_idle();
    compare("R12 resume after clear");

    // R9 retry overrun stops at once and resends
    clear_logs();
    ctl = 32'h1;
    reg_write(2'd0, 32'h0);
    inj_idx = 1; inj_out = 2'd3;
    push(mk_desc(16'h4000, 4'd2, 4'd0, 2'd2), ix);
    add_expect(ix, 0);
    etx_n = 2;
    reg_write(2'd0, ctl);
    wait_idle();
    repeat (20) @(posedge clk);
    compare("R9 immediate stop");
    reg_read(2'd3, rd);
    chk(rd == 32'h20, "R9 retry flag", 64'(rd), 64'h20);
    reg_read(2'd2, rd);
    chk(rd == 32'(ix), "R9 dequeue held", 64'(rd), 64'(ix));
    clear_logs();
    inj_idx = -1;
    add_expect(ix, 0);
    reg_write(2'd3, 32'h20);
    wait_idle();
    compare("R9 R12 full resend");

    // R10 memory error on a middle payload word
    clear_logs();
    ctl = 32'h5;
    reg_write(2'd0, 32'h4);
    push(mk_desc(16'h5000, 4'd2, 4'd0, 2'd1), i0);
    push(mk_desc(16'h5100, 4'd1, 4'd0, 2'd0), i1);
    err_en = 1; err_addr = 16'h5001;
    emem[0] = 16'h0100 + 16'(i0); emem[1] = 16'h5000; emem[2] = 16'h5001; emem_n = 3;
    reg_write(2'd0, ctl);
    wait_idle();
    repeat (10) @(posedge clk);
    compare("R10 drop and stop");
    reg_read(2'd3, rd);
    chk(rd == 32'h40, "R10 memory-error flag", 64'(rd), 64'h40);
    chk(irq == 1'b1, "R11 irq on memory error", 64'(irq), 1);
    reg_read(2'd2, rd);
    chk(rd == 32'(i1), "R10 dequeue advanced", 64'(rd), 64'(i1));
    err_en = 0;
    clear_logs();
    add_expect(i1, 0);
    reg_write(2'd3, 32'h40);
    wait_idle();
    compare("R10 R12 resume");
    reg_read(2'd3, rd);
    chk(rd == 32'h4, "R12 all clear", 64'(rd), 64'h4);

    // R5 R6 random rounds
    for (int r = 0; r < 4; r++) begin
      bit m = 1'($urandom);
      clear_logs();
      ctl = {30'b0, m, 1'b1};
      reg_write(2'd0, ctl);
      for (int i = 0; i < 5; i++) begin
        push(rnd_desc(), ix);
        add_expect(ix, m);
      end
      wait_idle();
      compare(m ? "R6 random round" : "R5 random round");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule